// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a clocked host and a 16-bit asynchronous static RAM. It turns each single-beat write request into a write cycle on the memory pins with correct timing. The host offers an address, a 16-bit data word and a 2-bit lane mask on a valid/ready pair. The block then drives chip select, write strobe, the two lane selects, the address bus, the outgoing data word and the tristate enable of the data bus. Only writes are handled.

The memory stores data only while chip select, at least one lane select and the write strobe are all low together. The sequencer lowers all three together and always lets the write strobe rise first. Data and address hold are therefore measured from that edge, while chip select, the lane selects, the address and the data stay unchanged across it.

Every timing minimum is a parameter in nanoseconds. Each one is converted to whole cycles of the clock-period parameter by rounding up. The converted values fix the strobe phase, the hold phase and the recovery phase, which is stretched until the full cycle minimum is met.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `sram_ce_n`, `sram_we_n`, `sram_ub_n` and `sram_lb_n` are high, `sram_dq_oe` is low and `req_ready` is high.
- R2: A request is taken on a rising clock edge only when `req_valid` and `req_ready` are both high. From the next cycle on, `req_ready` stays low until the cycle is complete. `req_valid` pulses while it is low change nothing on the memory pins.
- R3: In the cycle after acceptance, `sram_ce_n` goes low and stays low for STROBE + HOLD cycles. Over the same span, `sram_ub_n` equals the inverse of mask bit 1 and `sram_lb_n` equals the inverse of mask bit 0. Outside that span all three are high.
- R4: When the mask is nonzero, `sram_we_n` goes low together with `sram_ce_n` for STROBE cycles. STROBE is the largest of these values, each given in cycles: the strobe width, chip-select-to-end, address-to-end, lane-to-end, bus-release delay plus data setup, and bus-release delay plus one.
- R5: `sram_we_n` rises before any other strobe. For HOLD = max(1, address hold, data hold) cycles after it rises, chip select, the lane selects, `sram_addr` and `sram_dq_out` stay unchanged.
- R6: `sram_dq_oe` rises only after `sram_we_n` has been low for the bus-release delay in cycles, stays high through the hold phase, and falls together with `sram_ce_n` rising.
- R7: A request with mask 00 runs a full cycle with chip select low, but `sram_we_n` stays high and `sram_dq_oe` stays low.
- R8: Each nanosecond minimum becomes ceil(t / clock period) cycles, or 0 when t is 0. `req_ready` returns exactly max(STROBE + HOLD, cycle minimum in cycles) cycles after the accepting edge.
- R9: `sram_addr` and `sram_dq_out` carry the most recently accepted address and data from the cycle after acceptance until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq_out | output | 16 | Outgoing data word |
| sram_dq_oe | output | 1 | Data bus tristate enable, high drives |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |

## Verification
Writes are tried with each of the four lane masks. Only these separate the lane-select mapping, and the 00 case also confirms that the strobe and the data bus stay quiet. Requests arrive with random address, data and idle gaps. They also arrive back to back, which shows whether `req_ready` returns at the computed cycle. While the sequencer is busy, the bench holds `req_valid` high with unrelated address and data. The address and data pins after the cycle then show whether that request was wrongly captured.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STROBE  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Round a nanosecond minimum up to whole clock cycles; zero stays zero.
  function automatic int ns_to_cycles(input int t_ns, input int period_ns);
    if (t_ns <= 0) return 0;
    return (t_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RECOVER_CYC = 0,
  parameter int CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  output phase_e           phase_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] STROBE_LAST  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'((RECOVER_CYC > 0) ? RECOVER_CYC - 1 : 0);
  localparam bit               HAS_RECOVER  = (RECOVER_CYC > 0);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  // Clock enable: the sequencer only moves when busy or when a request lands.
  assign adv       = accept || (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (accept) phase_d = PH_STROBE;
      end
      PH_STROBE: begin
        if (cnt_q == STROBE_LAST) begin
          cnt_d   = '0;
          phase_d = PH_HOLD;
        end
      end
      PH_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          cnt_d   = '0;
          phase_d = HAS_RECOVER ? PH_RECOVER : PH_IDLE;
        end
      end
      PH_RECOVER: begin
        if (cnt_q == RECOVER_LAST) begin
          cnt_d   = '0;
          phase_d = PH_IDLE;
        end
      end
      default: begin
        cnt_d   = '0;
        phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (adv) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_wr_req_reg.sv
module sram_wr_req_reg #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANE_W-1:0] in_mask,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data,
  output logic [LANE_W-1:0] lat_mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
      lat_mask <= '0;
    end else if (load) begin
      lat_addr <= in_addr;
      lat_data <= in_data;
      lat_mask <= in_mask;
    end
  end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int HIZ_CYC = 1,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_data,
  input  logic [1:0]        lat_mask,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n
);

  localparam logic [CNT_W-1:0] HIZ_LAST = CNT_W'(HIZ_CYC);

  logic in_strobe, in_hold, active, has_lanes;
  logic oe_d, ce_d, we_d, ub_d, lb_d;

  always_comb begin
    in_strobe = (phase_q == PH_STROBE);
    in_hold   = (phase_q == PH_HOLD);
    active    = in_strobe || in_hold;
    has_lanes = |lat_mask;
    ce_d      = !active;
    we_d      = !(in_strobe && has_lanes);
    ub_d      = !(active && lat_mask[1]);
    lb_d      = !(active && lat_mask[0]);
    // The bus is driven only once the memory has let go of it, and is kept
    // through the hold phase so data stays put across the rising strobe.
    oe_d      = has_lanes && ((in_strobe && (cnt_q >= HIZ_LAST)) || in_hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_ub_n   <= 1'b1;
      sram_lb_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else begin
      sram_ce_n   <= ce_d;
      sram_we_n   <= we_d;
      sram_ub_n   <= ub_d;
      sram_lb_n   <= lb_d;
      sram_dq_oe  <= oe_d;
      sram_addr   <= lat_addr;
      sram_dq_out <= lat_data;
    end
  end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter int CLK_PERIOD_NS    = 5,
  parameter int T_CYCLE_NS       = 10,
  parameter int T_WE_PULSE_NS    = 7,
  parameter int T_CE_TO_END_NS   = 9,
  parameter int T_ADDR_TO_END_NS = 9,
  parameter int T_LANE_TO_END_NS = 9,
  parameter int T_DATA_SETUP_NS  = 5,
  parameter int T_DATA_HOLD_NS   = 0,
  parameter int T_ADDR_HOLD_NS   = 1,
  parameter int T_WE_TO_HIZ_NS   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  input  logic [1:0]        req_mask,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n
);

  localparam int DATA_W  = 16;
  localparam int C_WC    = ns_to_cycles(T_CYCLE_NS,       CLK_PERIOD_NS);
  localparam int C_PWE   = ns_to_cycles(T_WE_PULSE_NS,    CLK_PERIOD_NS);
  localparam int C_CE    = ns_to_cycles(T_CE_TO_END_NS,   CLK_PERIOD_NS);
  localparam int C_AW    = ns_to_cycles(T_ADDR_TO_END_NS, CLK_PERIOD_NS);
  localparam int C_LANE  = ns_to_cycles(T_LANE_TO_END_NS, CLK_PERIOD_NS);
  localparam int C_SD    = ns_to_cycles(T_DATA_SETUP_NS,  CLK_PERIOD_NS);
  localparam int C_HD    = ns_to_cycles(T_DATA_HOLD_NS,   CLK_PERIOD_NS);
  localparam int C_HA    = ns_to_cycles(T_ADDR_HOLD_NS,   CLK_PERIOD_NS);
  localparam int C_HIZ   = ns_to_cycles(T_WE_TO_HIZ_NS,   CLK_PERIOD_NS);
  localparam int STROBE  = imax(imax(imax(C_PWE, C_CE), imax(C_AW, C_LANE)),
                                imax(C_HIZ + C_SD, C_HIZ + 1));
  localparam int HOLD    = imax(1, imax(C_HA, C_HD));
  localparam int RECOVER = (C_WC > STROBE + HOLD) ? C_WC - STROBE - HOLD : 0;
  localparam int CNT_W   = $clog2(imax(imax(STROBE, HOLD), RECOVER) + 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               accept;
  logic [ADDR_W-1:0]  lat_addr;
  logic [DATA_W-1:0]  lat_data;
  logic [1:0]         lat_mask;

  sram_wr_seq #(
    .STROBE_CYC (STROBE),
    .HOLD_CYC   (HOLD),
    .RECOVER_CYC(RECOVER),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .accept   (accept),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q)
  );

  sram_wr_req_reg #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANE_W(2)
  ) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .in_addr (req_addr),
    .in_data (req_data),
    .in_mask (req_mask),
    .lat_addr(lat_addr),
    .lat_data(lat_data),
    .lat_mask(lat_mask)
  );

  sram_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HIZ_CYC(C_HIZ),
    .CNT_W  (CNT_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_q    (phase_q),
    .cnt_q      (cnt_q),
    .lat_addr   (lat_addr),
    .lat_data   (lat_data),
    .lat_mask   (lat_mask),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n)
  );

endmodule

// File: rtl/sram_wr_ctrl_chk.sv
module sram_wr_ctrl_chk #(
  parameter int ADDR_W     = 18,
  parameter int MIN_CE_GAP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [15:0]       sram_dq_out,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n
);

  logic       ce_prev;
  logic       ce_seen;
  logic [7:0] ce_gap;
  logic       ce_fall;

  assign ce_fall = ce_prev && !sram_ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev <= 1'b1;
      ce_seen <= 1'b0;
      ce_gap  <= '0;
    end else begin
      ce_prev <= sram_ce_n;
      if (ce_fall) begin
        ce_seen <= 1'b1;
        ce_gap  <= 8'd1;
      end else if (ce_gap != 8'hFF) begin
        ce_gap  <= ce_gap + 8'd1;
      end
    end
  end

  assert_idle_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_we_n && sram_ub_n && sram_lb_n));

  assert_we_needs_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && !(sram_ub_n && sram_lb_n)));

  assert_we_ends_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));

  assert_bus_after_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

  assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> (sram_we_n && sram_ce_n));

  assert_no_lane_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ub_n && sram_lb_n) |-> (sram_we_n && !sram_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_cycle_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && ce_seen) |-> (ce_gap >= 8'(MIN_CE_GAP)));

endmodule

bind sram_wr_ctrl sram_wr_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .sram_addr  (sram_addr),
  .sram_dq_out(sram_dq_out),
  .sram_dq_oe (sram_dq_oe),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_ub_n  (sram_ub_n),
  .sram_lb_n  (sram_lb_n)
);

// File: tb/test_sram_wr_ctrl.sv
`timescale 1ns/1ps
module test_sram_wr_ctrl;

  localparam int AW  = 18;
  localparam int PER = 5;

  function automatic int to_cyc(input int t);
    return (t == 0) ? 0 : (t + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected phase lengths from the default nanosecond minimums.
  localparam int E_HIZ    = to_cyc(5);
  localparam int E_STROBE = mx(mx(mx(to_cyc(7), to_cyc(9)), mx(to_cyc(9), to_cyc(9))),
                               mx(to_cyc(5) + to_cyc(5), to_cyc(5) + 1));
  localparam int E_HOLD   = mx(1, mx(to_cyc(1), to_cyc(0)));
  localparam int E_BUSY   = mx(E_STROBE + E_HOLD, to_cyc(10));

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_data;
  logic [1:0]    req_mask;
  logic [AW-1:0] sram_addr;
  logic [15:0]   sram_dq_out;
  logic          sram_dq_oe, sram_ce_n, sram_we_n, sram_ub_n, sram_lb_n;

  int checks = 0;
  int errors = 0;

  sram_wr_ctrl i_sram_wr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] pin_vec();
    return {sram_ce_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe};
  endfunction

  // Expected {ce_n, we_n, ub_n, lb_n, oe} k cycles after the accepting edge.
  function automatic logic [4:0] exp_pins(input int k, input logic [1:0] m);
    bit s, h, act, lanes;
    s     = (k >= 1) && (k <= E_STROBE);
    h     = (k > E_STROBE) && (k <= E_STROBE + E_HOLD);
    act   = s || h;
    lanes = (m != 2'b00);
    return {!act, !(s && lanes), !(act && m[1]), !(act && m[0]),
            lanes && ((s && (k - 1) >= E_HIZ) || h)};
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input int gap);
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    req_mask  = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // Unrelated request held while busy; it must be ignored (R2).
    req_addr = ~a;
    req_data = ~d;
    req_mask = ~m;
    for (int k = 1; k <= E_BUSY + 1; k++) begin
      @(negedge clk);
      check(pin_vec() == exp_pins(k, m), "R3/R4/R5/R6/R7", "pins",
            pin_vec(), exp_pins(k, m));
      check(req_ready == (k >= E_BUSY), "R8", "ready timing",
            req_ready, (k >= E_BUSY));
      check(sram_addr == a, "R9", "address", sram_addr, a);
      if (sram_dq_oe) check(sram_dq_out == d, "R5", "data", sram_dq_out, d);
      if (k == E_BUSY) req_valid = 1'b0;
    end
    check(sram_addr == a && sram_dq_out == d, "R2", "busy request ignored",
          {sram_addr, sram_dq_out}, {a, d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    check(pin_vec() == 5'b11110, "R1", "pins in reset", pin_vec(), 5'b11110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_vec() == 5'b11110, "R1", "pins after reset", pin_vec(), 5'b11110);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    // Directed: every lane mask, including the empty one (R7).
    do_write(18'h00001, 16'hA5C3, 2'b11, 0);
    do_write(18'h3FFFF, 16'h1234, 2'b01, 1);
    do_write(18'h15555, 16'hFFFF, 2'b10, 2);
    do_write(18'h2AAAA, 16'h0F0F, 2'b00, 0);
    do_write(18'h00000, 16'h0000, 2'b11, 0);

    for (int i = 0; i < 60; i++) begin
      do_write(AW'($urandom), 16'($urandom), 2'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)));
    end

    // Idle after the last cycle: all strobes inactive (R3).
    repeat (3) @(negedge clk);
    check(pin_vec() == 5'b11110, "R3", "idle pins", pin_vec(), 5'b11110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule